// File: doc/BRIEF.md
# Crystal clock digital trim unit

The block counts an oscillator clock down to a once-per-second tick and corrects the crystal's frequency error in coarse steps. It does not change the division ratio. Instead, once in every second it either removes one oscillator pulse from the count or adds one. With a 15-bit divider on a 32768 Hz clock, one pulse is about 30.5 ppm, so the trim gives a shift of plus or minus one step or none.

A 2-bit trim code sets the correction, and the unit holds that code in two registers. At power-on reset, both registers load a preset value. The first is a pending register, which the host can write only while the temperature-sense flag is low. The second is the register in force, which takes the pending value at each second boundary. The trim readback shows the code in force, so a write made in mid-second shows up on the readback at the next tick.

The divider is controlled by a two-state machine:
- `ST_COUNT` is the normal counting state.
- `ST_STRETCH` is one extra cycle held at count 0.

The transitions are:
- `ST_COUNT` to `ST_STRETCH` happens at count 0 when the code in force is the slow code.
- `ST_STRETCH` to `ST_COUNT` always happens on the next cycle.
- `ST_COUNT` to `ST_COUNT` covers every other cycle. For the fast code, this includes a jump from count 0 to count 2.

Top module: `xtal_trim_top`

## Requirements
- R1: While `por_n` is low, and in the first cycle after it rises, `sec_tick` is 0 and `trim_rd` equals the preset code (default 2'b10). The divider starts at count 0.
- R2: With the code in force at 2'b00 (trimming disabled) or 2'b10 (zero trim), successive ticks are exactly 2^DIV_W clock cycles apart.
- R3: With the code in force at 2'b01 (+30.5 ppm), successive ticks are 2^DIV_W - 1 cycles apart. The divider steps from count 0 directly to count 2.
- R4: With the code in force at 2'b11 (-30.5 ppm), successive ticks are 2^DIV_W + 1 cycles apart. The divider stays at count 0 for two cycles.
- R5: `sec_tick` is a single-cycle pulse. It rises in the first cycle after the divider wraps from its maximum count to 0.
- R6: A write (`trim_wr_en` high with `temp_sense_en` low) goes into the pending register on that clock edge. `trim_rd` keeps the old code until the next tick. In the tick cycle it shows the new code, and that code governs the period that ends at the following tick.
- R7: A write while `temp_sense_en` is 1 is ignored. The code in force after the following boundaries is unchanged.
- R8: Corrections happen only at count 0. From any other count, the divider advances by exactly one per cycle, modulo 2^DIV_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| trim_wr_en | input | 1 | Trim write strobe, one cycle per write |
| trim_wr_data | input | 2 | Trim code to write |
| temp_sense_en | input | 1 | Temperature sensing active; blocks trim writes |
| sec_tick | output | 1 | Trimmed one-second tick, single cycle |
| trim_rd | output | 2 | Trim code currently in force |

## Verification
The assertions assume that `por_n` is low when the clock starts. They also assume that `por_n` is released away from a rising edge, and that `trim_wr_data` and `temp_sense_en` are stable around the edge on which a write strobe is sampled. The bench drives every input on the falling clock edge and holds it for a whole cycle, so these conditions are met. It writes each code in mid-second, so a write never lands on the boundary cycle. A behavioural model then predicts every tick and readback value, which covers both the pending-to-active hand-over and the blocked writes.

// File: rtl/xtal_trim_pkg.sv
package xtal_trim_pkg;

    typedef enum logic [1:0] {
        TRIM_OFF  = 2'b00,
        TRIM_FAST = 2'b01,
        TRIM_NONE = 2'b10,
        TRIM_SLOW = 2'b11
    } trim_code_e;

    typedef enum logic {
        ST_COUNT   = 1'b0,
        ST_STRETCH = 1'b1
    } div_state_e;

endpackage

// File: rtl/xtal_trim_field.sv
module xtal_trim_field
    import xtal_trim_pkg::*;
#(
    parameter logic [1:0] PRESET_TRIM = 2'b10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    input  logic       tsense_en,
    input  logic       sec_end,
    output trim_code_e trim_act
);

    trim_code_e pend_q;
    trim_code_e act_q;
    logic       wr_ok;

    assign wr_ok = wr_en && !tsense_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= trim_code_e'(PRESET_TRIM);
            act_q  <= trim_code_e'(PRESET_TRIM);
        end else begin
            if (wr_ok) begin
                pend_q <= trim_code_e'(wr_data);
            end
            if (sec_end) begin
                act_q <= pend_q;
            end
        end
    end

    assign trim_act = act_q;

    // R7: a blocked write leaves the pending code untouched
    a_r7_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tsense_en) |=> $stable(pend_q));

    // R6: an accepted write lands in the pending register
    a_r6_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tsense_en) |=> (pend_q == $past(wr_data)));

    // R6: the code in force only moves on a boundary strobe from the divider
    a_r6_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_end |=> $stable(act_q));

endmodule

// File: rtl/xtal_trim_divider.sv
module xtal_trim_divider
    import xtal_trim_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  trim_code_e trim_act,
    output logic       sec_end,
    output logic       tick
);

    localparam logic [DIV_W-1:0] CNT_MAX  = {DIV_W{1'b1}};
    localparam logic [DIV_W-1:0] CNT_ZERO = '0;
    localparam logic [DIV_W-1:0] STEP_ONE = DIV_W'(1);
    localparam logic [DIV_W-1:0] STEP_TWO = DIV_W'(2);

    div_state_e       state_q, state_nx;
    logic [DIV_W-1:0] cnt_q, cnt_nx;
    logic             at_zero;

    assign at_zero = (cnt_q == CNT_ZERO);

    // next-state and divider step
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q + STEP_ONE;
        unique case (state_q)
            ST_COUNT: begin
                if (at_zero && trim_act == TRIM_FAST) begin
                    cnt_nx = cnt_q + STEP_TWO;
                end else if (at_zero && trim_act == TRIM_SLOW) begin
                    cnt_nx   = cnt_q;
                    state_nx = ST_STRETCH;
                end
            end
            ST_STRETCH: begin
                cnt_nx   = cnt_q + STEP_ONE;
                state_nx = ST_COUNT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            cnt_q   <= CNT_ZERO;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    assign sec_end = (state_q == ST_COUNT) && (cnt_q == CNT_MAX);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            tick <= sec_end;
        end
    end

    // R5: tick is one cycle wide and marks the first cycle at count 0
    a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    a_r5_tick_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (at_zero && state_q == ST_COUNT));

    // R4: the stretch state holds count 0 for a second cycle
    a_r4_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRETCH) |-> (at_zero && $past(cnt_q) == CNT_ZERO));

    // R8: away from count 0 the divider advances by one
    a_r8_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
        !at_zero |=> (cnt_q == $past(cnt_q) + STEP_ONE));

    // R3: fast code skips count 1
    a_r3_skip_one: assert property (@(posedge clk) disable iff (!rst_n)
        (at_zero && state_q == ST_COUNT && trim_act == TRIM_FAST) |=> (cnt_q == STEP_TWO));

endmodule

// File: rtl/xtal_trim_top.sv
module xtal_trim_top
    import xtal_trim_pkg::*;
#(
    parameter int         DIV_W       = 15,
    parameter logic [1:0] PRESET_TRIM = 2'b10
) (
    input  logic       clk_osc,
    input  logic       por_n,
    input  logic       trim_wr_en,
    input  logic [1:0] trim_wr_data,
    input  logic       temp_sense_en,
    output logic       sec_tick,
    output logic [1:0] trim_rd
);

    trim_code_e trim_act;
    logic       sec_end;

    xtal_trim_field #(
        .PRESET_TRIM (PRESET_TRIM)
    ) u_field (
        .clk       (clk_osc),
        .rst_n     (por_n),
        .wr_en     (trim_wr_en),
        .wr_data   (trim_wr_data),
        .tsense_en (temp_sense_en),
        .sec_end   (sec_end),
        .trim_act  (trim_act)
    );

    xtal_trim_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk      (clk_osc),
        .rst_n    (por_n),
        .trim_act (trim_act),
        .sec_end  (sec_end),
        .tick     (sec_tick)
    );

    assign trim_rd = trim_act;

    // R1: leaving reset, the preset is in force and no tick is pending
    a_r1_reset_state: assert property (@(posedge clk_osc) disable iff (!por_n)
        $rose(por_n) |-> (trim_rd == PRESET_TRIM && !sec_tick));

endmodule

// File: tb/test_xtal_trim_top.sv
module test_xtal_trim_top;

    localparam int         DIV_W  = 6;
    localparam int         N      = 1 << DIV_W;
    localparam logic [1:0] PRESET = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic       ts_en = 1'b0;
    logic       tick;
    logic [1:0] trim_rd;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R2";

    always #10 clk = ~clk;

    xtal_trim_top #(.DIV_W(DIV_W), .PRESET_TRIM(PRESET)) i_xtal_trim_top (
        .clk_osc       (clk),
        .por_n         (rst_n),
        .trim_wr_en    (wr_en),
        .trim_wr_data  (wr_data),
        .temp_sense_en (ts_en),
        .sec_tick      (tick),
        .trim_rd       (trim_rd)
    );

    function automatic int period_of(input logic [1:0] code);
        case (code)
            2'b01:   return N - 1;
            2'b11:   return N + 1;
            default: return N;
        endcase
    endfunction

    // behavioural reference: cycles left until the next tick
    int         m_left = N;
    logic [1:0] m_act = PRESET;
    logic [1:0] m_pend = PRESET;
    logic [1:0] m_old;
    logic       m_tick = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act  = PRESET;
            m_pend = PRESET;
            m_tick = 1'b0;
            m_left = period_of(PRESET);
        end else begin
            m_old = m_pend;
            if (wr_en && !ts_en) m_pend = wr_data;
            m_left = m_left - 1;
            if (m_left == 0) begin
                m_tick = 1'b1;
                m_act  = m_old;
                m_left = period_of(m_act);
            end else begin
                m_tick = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (tick !== m_tick || trim_rd !== m_act) begin
                errors++;
                $display("FAIL %s per-cycle: tick=%0b trim_rd=%b expected tick=%0b trim_rd=%b",
                         cur_req, tick, trim_rd, m_tick, m_act);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (tick !== 1'b1) @(negedge clk);
    endtask

    // from a tick, count cycles to the next one; also checks the pulse width
    task automatic measure(input int exp, input string req);
        int n;
        wait_tick();
        n = 0;
        @(negedge clk);
        n++;
        chk(tick === 1'b0, "R5", "tick width", int'(tick), 0);
        while (tick !== 1'b1) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp, req, "tick period", n, exp);
    endtask

    task automatic write_code(input logic [1:0] code);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = code;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(tick === 1'b0, "R1", "tick in reset", int'(tick), 0);
        chk(trim_rd === PRESET, "R1", "preset in reset", int'(trim_rd), int'(PRESET));
        rst_n = 1'b1;
        @(negedge clk);
        chk(trim_rd === PRESET, "R1", "preset after release", int'(trim_rd), int'(PRESET));

        // R2: zero-trim code
        cur_req = "R2";
        measure(N, "R2");
        measure(N, "R2");

        // R6 + R2: disabled code written mid-second
        repeat (10) @(negedge clk);
        cur_req = "R6";
        write_code(2'b00);
        @(negedge clk);
        chk(trim_rd === PRESET, "R6", "old code until boundary", int'(trim_rd), int'(PRESET));
        wait_tick();
        chk(trim_rd === 2'b00, "R6", "new code at tick", int'(trim_rd), 0);
        cur_req = "R2";
        measure(N, "R2");

        // R3: fast code
        repeat (7) @(negedge clk);
        cur_req = "R3";
        write_code(2'b01);
        measure(N - 1, "R3");
        measure(N - 1, "R3");

        // R4: slow code
        repeat (5) @(negedge clk);
        cur_req = "R4";
        write_code(2'b11);
        measure(N + 1, "R4");
        measure(N + 1, "R4");

        // R7: write blocked while sensing
        repeat (9) @(negedge clk);
        cur_req = "R7";
        ts_en = 1'b1;
        write_code(2'b01);
        ts_en = 1'b0;
        measure(N + 1, "R7");
        chk(trim_rd === 2'b11, "R7", "code after blocked write", int'(trim_rd), 3);
        measure(N + 1, "R7");

        // R1: preset recalled by a later power-on reset
        repeat (4) @(negedge clk);
        cur_req = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        chk(trim_rd === PRESET, "R1", "preset recalled", int'(trim_rd), int'(PRESET));
        chk(tick === 1'b0, "R1", "tick cleared", int'(tick), 0);
        rst_n = 1'b1;
        cur_req = "R8";
        measure(N, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule